// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters behind a small byte-wide host port. The host selects a target with a two-bit address. Codes 0, 1 and 2 reach the three counters, and code 3 reaches a write-only control register. A control byte binds one counter to a counting mode, a byte-access pattern and a number base. The counter then takes its start value through one or two data writes. Each counter decrements on its own tick input, is qualified by its own gate input, and drives one output line. The counter ticks are clock enables sampled on the system clock `clk`.

Two counting behaviours are provided. In the pulse-train (rate) behaviour the output falls for one tick period out of every N. In the triggered single-pulse (one-shot) behaviour a rising gate starts a low pulse N ticks long. Counts run in plain binary or as four packed decimal digits. A snapshot command freezes a copy of the count for the host to read while the live counter keeps running.

Each channel is driven by an enumerated state machine with five states.
- `ST_IDLE`: the channel is programmed and has no count.
- `ST_ARMED`: a one-shot count is loaded and the channel waits for a trigger.
- `ST_FIRE`: the one-shot pulse is running.
- `ST_SPENT`: the pulse has ended and the channel can be triggered again.
- `ST_CYCLE`: the rate generator is running.

The transitions are as follows.
- Any accepted program command leads to `ST_IDLE` (program).
- A completed count load leads to `ST_CYCLE` in rate mode and to `ST_ARMED` in one-shot mode (load).
- A rising gate moves `ST_ARMED` or `ST_SPENT` to `ST_FIRE` (trigger).
- A rising gate in `ST_FIRE` stays in `ST_FIRE` and reloads the count (retrigger).
- `ST_FIRE` moves to `ST_SPENT` when the count reaches zero (expire).

Top module: `interval_timer3`

## Requirements
- R1: After reset every output line is high, every counter reads 0x0000 and each counter's access pattern is low byte then high byte.
- R2: A host access with `cs_n` and `rd_n` low and `addr` 0, 1 or 2 returns a byte of counter 0, 1 or 2 on `rdata` in the same cycle. A read at `addr` 3 returns 0x00. Each read strobe is taken on the rising `clk` edge while it is low.
- R3: A control byte written at `addr` 3 has these fields: bits 7:6 select the counter, bits 5:4 the access pattern, bits 3:1 the mode and bit 0 the base (1 = decimal). A select value of 3 is ignored. For access patterns other than 00, a mode field other than 001 (one-shot) or 010 (rate) is also ignored. An ignored byte leaves the counter, the output line and the byte steering unchanged.
- R4: The access pattern codes are 01 for the low byte only, 10 for the high byte only and 11 for the low byte then the high byte. A low-only write loads {0x00,d} and a high-only write loads {d,0x00}. Reads return the matching byte. In the 11 pattern, separate write and read toggles alternate low and high, and an accepted program command resets both toggles to low.
- R5: In rate mode with a load of N ≥ 2 and the gate high, each tick decrements the count. The output is low exactly while the count equals 1. The tick after that reloads N and raises the output, so the output period is N ticks.
- R6: In rate mode, ticks that arrive while the gate is low change neither the count nor the output.
- R7: In one-shot mode, loading the count leaves the output high until a rising gate. The rising gate copies the load value into the count and drives the output low. The output returns high on the tick that brings the count to 0. A new rising gate during the pulse restarts it from the full load value.
- R8: In decimal base, a decrement borrows digit by digit and 0x0000 steps to 0x9999. In binary base, 0x0000 steps to 0xFFFF.
- R9: A control byte with access code 00 copies the addressed counter's live count into a snapshot. Reads return the snapshot until the access pattern has been fully read, while counting goes on. A second snapshot command given while one is still held is ignored.
- R10: Ticks, gates and host traffic aimed at one counter leave the count and output of the other counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target select: counters 0..2, control register 3 |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (combinational) |
| cnt_tick | input | 3 | Per-counter decrement enable |
| gate | input | 3 | Per-counter gate |
| tout | output | 3 | Per-counter output line |

## Verification
A corrupted state register or count shows up on `tout` at the next tick. The visible faults are a low phase that lasts one tick too long or too short, a one-shot pulse that never starts, and a pulse that never ends. A wrong digit borrow or a wrong byte-toggle value appears on the first host read after it, as a wrong byte or as swapped halves. A snapshot that is dropped too early is visible as soon as the second byte is read, because that byte then follows the moving live count instead of the frozen one.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_LOHI = 2'b11
    } acc_e;

    typedef enum logic {
        KIND_ONESHOT = 1'b0,
        KIND_RATE    = 1'b1
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_FIRE  = 3'd2,
        ST_SPENT = 3'd3,
        ST_CYCLE = 3'd4
    } chan_st_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       dec;
    } cword_t;

    localparam logic [2:0] MODE_CODE_ONESHOT = 3'b001;
    localparam logic [2:0] MODE_CODE_RATE    = 3'b010;

endpackage

// File: rtl/pit_downstep.sv
module pit_downstep #(
    parameter int NDIG = 4,
    localparam int CW  = 4 * NDIG
) (
    input  logic [CW-1:0] val_i,
    input  logic          dec_i,
    output logic [CW-1:0] nxt_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [NDIG:0]   brw;
    logic [CW-1:0]   dec_val;

    assign brw[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = val_i[4*g +: 4];
        assign dec_val[4*g +: 4] = brw[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
        assign brw[g+1] = brw[g] & (dig == 4'd0);
    end

    assign nxt_o = dec_i ? dec_val : (val_i - ONE);

    always_comb begin
        if (dec_i && val_i == '0) begin
            assert_bcd_wrap_R8: assert (nxt_o == {NDIG{4'd9}})
                else $error("decimal wrap from zero wrong");
        end
    end

endmodule

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output cword_t        cw_o,
    output logic [NCH-1:0] cw_we_o,
    output logic [NCH-1:0] dat_we_o,
    output logic [NCH-1:0] rd_stb_o
);
    localparam logic [1:0] CTRL_ADDR = 2'b11;

    logic wr_act, rd_act;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;
    assign cw_o   = cword_t'(wdata);

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign cw_we_o[g]  = wr_act && (addr == CTRL_ADDR) && (cw_o.sel == 2'(g));
        assign dat_we_o[g] = wr_act && (addr == 2'(g));
        assign rd_stb_o[g] = rd_act && (addr == 2'(g));
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int NDIG = 4,
    parameter int DW   = 8,
    localparam int CW  = 4 * NDIG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          gate_i,
    input  logic          cw_we_i,
    input  cword_t        cw_i,
    input  logic          wr_we_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_stb_i,
    output logic [DW-1:0] rd_byte_o,
    output logic          out_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    chan_st_e      st_q, st_d;
    kind_e         kind_q;
    acc_e          acc_q;
    logic          dec_q;
    logic [CW-1:0] count_q, reload_q, latch_q;
    logic [DW-1:0] lo_stage_q;
    logic          held_q, wr_hi_q, rd_hi_q, out_q, gate_q;

    logic [CW-1:0] dec_nxt, cycle_nxt, load_val, src;
    logic          cw_prog, snap_cmd, load_go, gate_rise, mode_ok;

    pit_downstep #(.NDIG(NDIG)) u_step (
        .val_i (count_q),
        .dec_i (dec_q),
        .nxt_o (dec_nxt)
    );

    assign mode_ok   = (cw_i.mode == MODE_CODE_ONESHOT) || (cw_i.mode == MODE_CODE_RATE);
    assign cw_prog   = cw_we_i && (cw_i.acc != ACC_SNAP) && mode_ok;
    assign snap_cmd  = cw_we_i && (cw_i.acc == ACC_SNAP);
    assign gate_rise = gate_i && !gate_q;
    assign cycle_nxt = (count_q == ONE) ? reload_q : dec_nxt;

    always_comb begin
        load_go  = 1'b0;
        load_val = reload_q;
        unique case (acc_q)
            ACC_LO:   begin load_go = wr_we_i; load_val = {{DW{1'b0}}, wr_data_i}; end
            ACC_HI:   begin load_go = wr_we_i; load_val = {wr_data_i, {DW{1'b0}}}; end
            ACC_LOHI: begin load_go = wr_we_i && wr_hi_q; load_val = {wr_data_i, lo_stage_q}; end
            default:  begin load_go = 1'b0; end
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (cw_prog) begin
            st_d = ST_IDLE;
        end else if (load_go) begin
            st_d = (kind_q == KIND_RATE) ? ST_CYCLE : ST_ARMED;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_CYCLE:  st_d = st_q;
                ST_ARMED, ST_SPENT: if (gate_rise) st_d = ST_FIRE;
                ST_FIRE:            if (!gate_rise && tick_i && dec_nxt == '0) st_d = ST_SPENT;
                default:            st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (cw_prog || load_go) begin
            out_q <= 1'b1;
        end else begin
            unique case (st_q)
                ST_ARMED, ST_SPENT: if (gate_rise) out_q <= 1'b0;
                ST_FIRE: begin
                    if (gate_rise)                       out_q <= 1'b0;
                    else if (tick_i && dec_nxt == '0)    out_q <= 1'b1;
                end
                ST_CYCLE: if (tick_i && gate_i) out_q <= (cycle_nxt != ONE);
                default: out_q <= out_q;
            endcase
        end
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            gate_q   <= 1'b0;
        end else begin
            gate_q <= gate_i;
            if (cw_prog) begin
                count_q <= count_q;
            end else if (load_go) begin
                reload_q <= load_val;
                if (kind_q == KIND_RATE) count_q <= load_val;
            end else begin
                unique case (st_q)
                    ST_ARMED: if (gate_rise) count_q <= reload_q;
                    ST_FIRE, ST_SPENT: begin
                        if (gate_rise)   count_q <= reload_q;
                        else if (tick_i) count_q <= dec_nxt;
                    end
                    ST_CYCLE: if (tick_i && gate_i) count_q <= cycle_nxt;
                    default: count_q <= count_q;
                endcase
            end
        end
    end

    // host-side configuration, byte steering and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= KIND_ONESHOT;
            acc_q      <= ACC_LOHI;
            dec_q      <= 1'b0;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            held_q     <= 1'b0;
            latch_q    <= '0;
            lo_stage_q <= '0;
        end else if (cw_prog) begin
            kind_q  <= (cw_i.mode == MODE_CODE_RATE) ? KIND_RATE : KIND_ONESHOT;
            acc_q   <= cw_i.acc;
            dec_q   <= cw_i.dec;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            if (snap_cmd && !held_q) begin
                latch_q <= count_q;
                held_q  <= 1'b1;
            end
            if (wr_we_i && acc_q == ACC_LOHI) begin
                if (!wr_hi_q) lo_stage_q <= wr_data_i;
                wr_hi_q <= !wr_hi_q;
            end
            if (rd_stb_i) begin
                if (acc_q == ACC_LOHI) begin
                    rd_hi_q <= !rd_hi_q;
                    if (rd_hi_q) held_q <= 1'b0;
                end else begin
                    held_q <= 1'b0;
                end
            end
        end
    end

    assign src       = held_q ? latch_q : count_q;
    assign rd_byte_o = (acc_q == ACC_HI || (acc_q == ACC_LOHI && rd_hi_q)) ? src[CW-1:DW] : src[DW-1:0];
    assign out_o     = out_q;

    assert_idle_out_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> out_q);

    assert_low_only_at_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CYCLE && !out_q) |-> (count_q == ONE));

    assert_gate_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CYCLE && !gate_i && !cw_we_i && !wr_we_i) |=> $stable(count_q));

    assert_trigger_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ARMED || st_q == ST_FIRE || st_q == ST_SPENT) && gate_rise && !cw_we_i && !wr_we_i)
        |=> !out_q);

    assert_spent_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SPENT) |-> out_q);

    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !rd_stb_i && !cw_we_i) |=> (held_q && $stable(latch_q)));

endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
    import pit_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int NDIG = 4,
    parameter int DW   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [1:0]     addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [NCH-1:0] cnt_tick,
    input  logic [NCH-1:0] gate,
    output logic [NCH-1:0] tout
);
    cword_t         cw;
    logic [NCH-1:0] cw_we, dat_we, rd_stb;
    logic [DW-1:0]  rd_byte [NCH];

    pit_bus_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .wdata    (wdata),
        .cw_o     (cw),
        .cw_we_o  (cw_we),
        .dat_we_o (dat_we),
        .rd_stb_o (rd_stb)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pit_channel #(.NDIG(NDIG), .DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (cnt_tick[g]),
            .gate_i    (gate[g]),
            .cw_we_i   (cw_we[g]),
            .cw_i      (cw),
            .wr_we_i   (dat_we[g]),
            .wr_data_i (wdata),
            .rd_stb_i  (rd_stb[g]),
            .rd_byte_o (rd_byte[g]),
            .out_o     (tout[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (!cs_n && !rd_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == 2'(i)) rdata = rd_byte[i];
            end
        end
    end

    assert_ctrl_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == 2'b11) |-> (rdata == '0));

endmodule

// File: tb/interval_timer3_tb.sv
module interval_timer3_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] tk = 3'b000;
    logic [2:0] gate = 3'b000;
    logic [2:0] tout;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    interval_timer3 dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cnt_tick(tk), .gate(gate), .tout(tout)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic rd16(input logic [1:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a, hi);
        v = {hi, lo};
    endtask

    task automatic tick(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tk[ch] = 1'b1;
            @(negedge clk); tk[ch] = 1'b0;
        end
    endtask

    task automatic set_gate(input int ch, input logic v);
        @(negedge clk); gate[ch] = v;
        @(negedge clk);
    endtask

    task automatic test_reset();
        logic [15:0] v; logic [7:0] b;
        check("R1 outputs high", {13'd0, tout}, 16'h0007);
        rd16(2'd0, v); check("R1 counter0 zero", v, 16'h0000);
        rd16(2'd2, v); check("R1 counter2 zero", v, 16'h0000);
        rd(2'd3, b);   check("R2 ctrl read zero", {8'd0, b}, 16'h0000);
    endtask

    task automatic test_rate();
        logic [15:0] v;
        logic exp_out [7] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
        gate[0] = 1'b1;
        wr(2'd3, 8'h34); wr(2'd0, 8'h04); wr(2'd0, 8'h00);
        check("R5 out high after load", {15'd0, tout[0]}, 16'h1);
        for (int i = 0; i < 7; i++) begin
            tick(0, 1);
            check($sformatf("R5 rate out tick %0d", i + 1), {15'd0, tout[0]}, {15'd0, exp_out[i]});
        end
        rd16(2'd0, v); check("R2 read counter0 count", v, 16'h0001);
    endtask

    task automatic test_gate_halt();
        logic [15:0] v;
        set_gate(0, 1'b0);
        tick(0, 3);
        rd16(2'd0, v);  check("R6 count frozen", v, 16'h0001);
        check("R6 out held", {15'd0, tout[0]}, 16'h0);
        set_gate(0, 1'b1);
        tick(0, 1);
        rd16(2'd0, v);  check("R6 resumes reload", v, 16'h0004);
        check("R5 out high after reload", {15'd0, tout[0]}, 16'h1);
    endtask

    task automatic test_oneshot();
        logic [15:0] v;
        gate[1] = 1'b0;
        wr(2'd3, 8'h72); wr(2'd1, 8'h03); wr(2'd1, 8'h00);
        tick(1, 2);
        check("R7 armed stays high", {15'd0, tout[1]}, 16'h1);
        set_gate(1, 1'b1);
        check("R7 trigger drives low", {15'd0, tout[1]}, 16'h0);
        rd16(2'd1, v); check("R7 trigger loads count", v, 16'h0003);
        tick(1, 2);
        check("R7 still low before zero", {15'd0, tout[1]}, 16'h0);
        set_gate(1, 1'b0);
        set_gate(1, 1'b1);
        rd16(2'd1, v); check("R7 retrigger reloads", v, 16'h0003);
        tick(1, 2);
        check("R7 low after retrigger", {15'd0, tout[1]}, 16'h0);
        tick(1, 1);
        check("R7 high at zero", {15'd0, tout[1]}, 16'h1);
    endtask

    task automatic test_bcd();
        logic [15:0] v;
        gate[2] = 1'b1;
        wr(2'd3, 8'hB5); wr(2'd2, 8'h00); wr(2'd2, 8'h00);
        tick(2, 1);
        rd16(2'd2, v); check("R8 decimal wrap", v, 16'h9999);
        tick(2, 1);
        rd16(2'd2, v); check("R8 decimal step", v, 16'h9998);
        wr(2'd3, 8'hB5); wr(2'd2, 8'h10); wr(2'd2, 8'h00);
        tick(2, 1);
        rd16(2'd2, v); check("R8 decimal borrow", v, 16'h0009);
        wr(2'd3, 8'hB4); wr(2'd2, 8'h00); wr(2'd2, 8'h00);
        tick(2, 1);
        rd16(2'd2, v); check("R8 binary wrap", v, 16'hFFFF);
        tick(0, 1);
        rd16(2'd2, v); check("R10 ch2 unaffected", v, 16'hFFFF);
        rd16(2'd0, v); check("R10 ch0 own tick", v, 16'h0003);
    endtask

    task automatic test_access();
        logic [7:0] b;
        wr(2'd3, 8'h54); wr(2'd1, 8'h05);
        rd(2'd1, b); check("R4 low only read", {8'd0, b}, 16'h0005);
        rd(2'd1, b); check("R4 low only no toggle", {8'd0, b}, 16'h0005);
        tick(1, 1);
        rd(2'd1, b); check("R4 low only counts", {8'd0, b}, 16'h0004);
        wr(2'd3, 8'h64); wr(2'd1, 8'h02);
        rd(2'd1, b); check("R4 high only read", {8'd0, b}, 16'h0002);
        tick(1, 1);
        rd(2'd1, b); check("R4 high byte after step", {8'd0, b}, 16'h0001);
    endtask

    task automatic test_latch();
        logic [7:0] b; logic [15:0] v;
        gate[0] = 1'b1;
        wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h10);
        tick(0, 5);
        wr(2'd3, 8'h00);
        tick(0, 3);
        wr(2'd3, 8'h00);
        tick(0, 1);
        rd(2'd0, b); check("R9 snapshot low", {8'd0, b}, 16'h00FB);
        rd(2'd0, b); check("R9 snapshot high", {8'd0, b}, 16'h000F);
        rd16(2'd0, v); check("R9 live after release", v, 16'h0FF7);
    endtask

    task automatic test_ignored();
        logic [15:0] v;
        wr(2'd3, 8'hF4);
        wr(2'd3, 8'h30);
        tick(0, 1);
        rd16(2'd0, v); check("R3 ignored words", v, 16'h0FF6);
        check("R3 out untouched", {15'd0, tout[0]}, 16'h1);
        wr(2'd3, 8'h34); wr(2'd0, 8'h20);
        wr(2'd3, 8'h34); wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        rd16(2'd0, v); check("R4 program resets toggle", v, 16'h0005);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_rate();
        test_gate_halt();
        test_oneshot();
        test_bcd();
        test_access();
        test_latch();
        test_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule